// File: doc/BRIEF.md
# Serial status and control registers

This block is the processor-facing register file of a FIFO-based serial controller. It sits between a simple word-aligned register bus and the datapath parts of the controller (receive FIFO, transmit and receive shifters, break detector, idle timer), which it talks to only through strobes and plain level signals. It stores the line configuration (mode, bit rate, control and port bytes, plus a 16-bit FIFO control word), keeps five status flags, and drives the transmit and receive interrupt lines.

Software writes a byte to the transmit data offset to send it. The block turns that write into a one-cycle strobe carrying the byte. Received bytes are read from the receive data offset. That read returns the FIFO head and pops the FIFO in the same cycle. The receive FIFO reports each accepted byte with a push strobe alongside its occupancy, and the block compares the new occupancy against a trigger level picked by the FIFO control word. Status flags are cleared by writing zeros to them, and a status read while the transmitter is enabled re-arms the transmit flags.

Top module: `sercfg_regs`

## Requirements
- R1: Registers sit at byte offsets mode 0x00, bit rate 0x04, control 0x08, transmit data 0x0C, status 0x10, receive data 0x14, FIFO control 0x18, count 0x1C, port 0x20 and line status 0x24. Reads of line status, of transmit data, of any other offset and of any address whose two low bits are not zero return 0. Writes to those addresses, and to the receive data and count offsets, change nothing. When a write and a read are requested together, the read is dropped.
- R2: After reset, mode reads 0x00, bit rate 0xFF, control 0x20, port 0x00 and FIFO control 0x0000. Status reads 0x60, and both interrupt lines and all strobes are low.
- R3: Writes are masked before storage: mode with 0x7B, control with 0xFA, port with 0xF3. Bit rate keeps the whole written byte and FIFO control keeps the whole 16-bit word.
- R4: The status byte carries transmit end in bit 6, transmit empty in bit 5, break in bit 4, receive full in bit 1 and data ready in bit 0, and reads 0 elsewhere. A status read returns the flags as they stood before the read. If control bit 5 (transmit enable) is 1, the read then sets transmit end and transmit empty.
- R5: A status write clears each of the five flags whose bit is written 0 and leaves each flag whose bit is written 1 unchanged.
- R6: A control write with bit 5 at 0 sets transmit end. The transmit interrupt line equals stored control bit 7.
- R7: A write to transmit data raises tx_strobe for exactly one cycle with tx_byte equal to the low byte written, and clears transmit empty.
- R8: A brk_det pulse sets the break flag. An rx_idle_tmo pulse sets data ready and, when control bit 6 (receive interrupt enable) is 1, raises the receive interrupt.
- R9: FIFO control bits 7:6 select the receive trigger: 00 selects 1, 01 selects 4, 10 selects 8 and 11 selects 14. An rx_push with occupancy rx_count before the push sets receive full when rx_count+1 is at least the trigger. It also raises the receive interrupt if control bit 6 is 1.
- R10: The receive interrupt drops on a control write with bit 6 at 0, and on a status write with bit 1 or bit 0 at 0.
- R11: A receive data read while rx_count is non-zero returns rx_head and asserts rx_pop in the same cycle as the request. Receive full clears when rx_count-1 is below the trigger. With rx_count zero, the read returns 0 and rx_pop stays low.
- R12: A FIFO control write with bit 1 set pulses fifo_clr for one cycle.
- R13: A count read returns rx_count.
- R14: In a cycle where a hardware event (push reaching the trigger, break, idle timeout) and a software clear of the same flag or interrupt coincide, the event wins. The only exception is a control write with bit 6 at 0, which always leaves the receive interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write request |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_head | input | 8 | Byte at the receive FIFO head |
| rx_push | input | 1 | Receive FIFO accepted a byte this cycle |
| rx_pop | output | 1 | Remove the receive FIFO head |
| rx_idle_tmo | input | 1 | Receive idle timeout strobe |
| brk_det | input | 1 | Break detected strobe |
| fifo_clr | output | 1 | Receive FIFO reset pulse |
| tx_strobe | output | 1 | Transmit byte valid, one cycle |
| tx_byte | output | 8 | Byte to transmit |
| mode_o | output | 8 | Stored mode byte |
| baud_o | output | 8 | Stored bit rate byte |
| ctrl_o | output | 8 | Stored control byte |
| port_o | output | 8 | Stored port byte |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |

## Verification
A write or an input strobe takes effect at the next rising edge. Stored registers, flags, interrupts, tx_strobe and fifo_clr are therefore due one edge after the request and are sampled at the falling edge that follows it. Read data is also captured at the edge that accepts the read and is sampled at that same falling edge. rx_pop is combinational from the request and is sampled a moment after the inputs are driven, before the accepting edge. Pulse outputs are checked again one cycle later to confirm they last exactly one cycle.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    localparam int NUM_REGS = 10;

    // register index = byte offset / 4; order is fixed by the address map
    typedef enum logic [3:0] {
        SEL_MODE = 4'd0,
        SEL_BAUD = 4'd1,
        SEL_CTRL = 4'd2,
        SEL_TXD  = 4'd3,
        SEL_STAT = 4'd4,
        SEL_RXD  = 4'd5,
        SEL_FCTL = 4'd6,
        SEL_CNT  = 4'd7,
        SEL_PORT = 4'd8,
        SEL_LSR  = 4'd9,
        SEL_NONE = 4'd15
    } reg_sel_e;

    localparam logic [7:0] MODE_KEEP  = 8'h7B;
    localparam logic [7:0] CTRL_KEEP  = 8'hFA;
    localparam logic [7:0] PORT_KEEP  = 8'hF3;
    localparam logic [7:0] BAUD_INIT  = 8'hFF;
    localparam logic [7:0] CTRL_INIT  = 8'h20;

    localparam int CTL_TXEN = 5;
    localparam int CTL_RXIE = 6;
    localparam int CTL_TXIE = 7;
    localparam int FC_RXRST = 1;

    localparam int ST_TEND = 6;
    localparam int ST_TDE  = 5;
    localparam int ST_BRK  = 4;
    localparam int ST_FULL = 1;
    localparam int ST_RDY  = 0;

    typedef struct packed {
        logic tend;
        logic tde;
        logic brk;
        logic full;
        logic rdy;
    } flags_t;

    localparam flags_t FLAGS_INIT = '{tend: 1'b1, tde: 1'b1, brk: 1'b0,
                                      full: 1'b0, rdy: 1'b0};

    function automatic logic [7:0] pack_status(flags_t f);
        logic [7:0] r;
        r          = '0;
        r[ST_TEND] = f.tend;
        r[ST_TDE]  = f.tde;
        r[ST_BRK]  = f.brk;
        r[ST_FULL] = f.full;
        r[ST_RDY]  = f.rdy;
        return r;
    endfunction

    function automatic int unsigned trig_level(logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/sercfg_decode.sv
module sercfg_decode
    import sercfg_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0]   addr,
    output reg_sel_e            sel,
    output logic [NUM_REGS-1:0] hit
);
    localparam int IDX_W = ADDR_W - 2;

    logic aligned;
    assign aligned = (addr[1:0] == 2'b00);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        assign hit[i] = aligned && (addr[ADDR_W-1:2] == IDX_W'(i));
    end

    always_comb begin
        sel = SEL_NONE;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit[i]) sel = reg_sel_e'(4'(i));
        end
    end

    // R1: at most one register is addressed
    always_comb begin
        if (!$isunknown(addr)) begin
            a_r1_one_select: assert ($onehot0(hit));
        end
    end

endmodule

// File: rtl/sercfg_flags.sv
module sercfg_flags
    import sercfg_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stat,
    input  logic             wr_ctrl,
    input  logic             wr_txd,
    input  logic             rd_stat,
    input  logic             rd_pop,
    input  logic [7:0]       wbyte,
    input  logic [7:0]       ctrl_q,
    input  logic [1:0]       trig_code,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_push,
    input  logic             rx_idle_tmo,
    input  logic             brk_det,
    output flags_t           flags,
    output logic             rx_irq
);
    localparam int OCC_W = CNT_W + 1;

    logic [OCC_W-1:0] trig;
    logic [OCC_W-1:0] occ;
    logic             push_hit;
    logic             pop_below;
    flags_t           nx;
    logic             irq_nx;

    assign trig      = OCC_W'(trig_level(trig_code));
    assign occ       = {1'b0, rx_count};
    assign push_hit  = rx_push && ((occ + OCC_W'(1)) >= trig);
    assign pop_below = rd_pop && (occ <= trig);

    always_comb begin
        nx = flags;
        if (wr_stat) begin
            if (!wbyte[ST_TEND]) nx.tend = 1'b0;
            if (!wbyte[ST_TDE])  nx.tde  = 1'b0;
            if (!wbyte[ST_BRK])  nx.brk  = 1'b0;
            if (!wbyte[ST_FULL]) nx.full = 1'b0;
            if (!wbyte[ST_RDY])  nx.rdy  = 1'b0;
        end
        if (wr_ctrl && !wbyte[CTL_TXEN]) nx.tend = 1'b1;
        if (wr_txd) nx.tde = 1'b0;
        if (rd_stat && ctrl_q[CTL_TXEN]) begin
            nx.tend = 1'b1;
            nx.tde  = 1'b1;
        end
        if (pop_below)   nx.full = 1'b0;
        if (push_hit)    nx.full = 1'b1;
        if (brk_det)     nx.brk  = 1'b1;
        if (rx_idle_tmo) nx.rdy  = 1'b1;

        irq_nx = rx_irq;
        if (wr_stat && (!wbyte[ST_FULL] || !wbyte[ST_RDY])) irq_nx = 1'b0;
        if ((push_hit || rx_idle_tmo) && ctrl_q[CTL_RXIE])    irq_nx = 1'b1;
        if (wr_ctrl && !wbyte[CTL_RXIE])                      irq_nx = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= FLAGS_INIT;
            rx_irq <= 1'b0;
        end else begin
            flags  <= nx;
            rx_irq <= irq_nx;
        end
    end

    a_r7_txd_empties: assert property (@(posedge clk) disable iff (rst)
        wr_txd |=> !flags.tde);
    a_r6_txoff_sets_end: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !wbyte[CTL_TXEN]) |=> flags.tend);
    a_r4_read_rearms: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && ctrl_q[CTL_TXEN]) |=> (flags.tend && flags.tde));
    a_r8_break_sets: assert property (@(posedge clk) disable iff (rst)
        brk_det |=> flags.brk);
    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> ctrl_q[CTL_RXIE]);

endmodule

// File: rtl/sercfg_rdmux.sv
module sercfg_rdmux
    import sercfg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  reg_sel_e          sel,
    input  logic [7:0]        mode_q,
    input  logic [7:0]        baud_q,
    input  logic [7:0]        ctrl_q,
    input  logic [7:0]        port_q,
    input  logic [DATA_W-1:0] fctl_q,
    input  logic [7:0]        status,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [7:0]        rx_head,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] word;

    always_comb begin
        word = '0;
        case (sel)
            SEL_MODE: word = DATA_W'(mode_q);
            SEL_BAUD: word = DATA_W'(baud_q);
            SEL_CTRL: word = DATA_W'(ctrl_q);
            SEL_STAT: word = DATA_W'(status);
            SEL_RXD:  word = (rx_count != '0) ? DATA_W'(rx_head) : '0;
            SEL_FCTL: word = fctl_q;
            SEL_CNT:  word = DATA_W'(rx_count);
            SEL_PORT: word = DATA_W'(port_q);
            default:  word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= word;
        else         rdata <= '0;
    end

    a_r1_unmapped_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd && (sel == SEL_NONE || sel == SEL_LSR || sel == SEL_TXD)) |=> (rdata == '0));

endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
    import sercfg_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [7:0]        rx_head,
    input  logic              rx_push,
    output logic              rx_pop,
    input  logic              rx_idle_tmo,
    input  logic              brk_det,
    output logic              fifo_clr,
    output logic              tx_strobe,
    output logic [7:0]        tx_byte,
    output logic [7:0]        mode_o,
    output logic [7:0]        baud_o,
    output logic [7:0]        ctrl_o,
    output logic [7:0]        port_o,
    output logic              tx_irq,
    output logic              rx_irq
);
    reg_sel_e            sel;
    logic [NUM_REGS-1:0] hit;
    logic                rd;
    logic [7:0]          wbyte;
    logic [7:0]          mode_q, baud_q, ctrl_q, port_q;
    logic [DATA_W-1:0]   fctl_q;
    flags_t              flags;
    logic                wr_mode, wr_baud, wr_ctrl, wr_txd, wr_stat, wr_fctl, wr_port;
    logic                rd_stat, rd_pop;

    sercfg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .hit  (hit)
    );

    assign rd      = bus_rd && !bus_wr;
    assign wbyte   = bus_wdata[7:0];
    assign wr_mode = bus_wr && hit[SEL_MODE];
    assign wr_baud = bus_wr && hit[SEL_BAUD];
    assign wr_ctrl = bus_wr && hit[SEL_CTRL];
    assign wr_txd  = bus_wr && hit[SEL_TXD];
    assign wr_stat = bus_wr && hit[SEL_STAT];
    assign wr_fctl = bus_wr && hit[SEL_FCTL];
    assign wr_port = bus_wr && hit[SEL_PORT];
    assign rd_stat = rd && hit[SEL_STAT];
    assign rd_pop  = rd && hit[SEL_RXD] && (rx_count != '0);
    assign rx_pop  = rd_pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            baud_q    <= BAUD_INIT;
            ctrl_q    <= CTRL_INIT;
            port_q    <= '0;
            fctl_q    <= '0;
            tx_strobe <= 1'b0;
            tx_byte   <= '0;
            fifo_clr  <= 1'b0;
        end else begin
            if (wr_mode) mode_q <= wbyte & MODE_KEEP;
            if (wr_baud) baud_q <= wbyte;
            if (wr_ctrl) ctrl_q <= wbyte & CTRL_KEEP;
            if (wr_port) port_q <= wbyte & PORT_KEEP;
            if (wr_fctl) fctl_q <= bus_wdata;
            tx_strobe <= wr_txd;
            if (wr_txd) tx_byte <= wbyte;
            fifo_clr  <= wr_fctl && bus_wdata[FC_RXRST];
        end
    end

    sercfg_flags #(.CNT_W(CNT_W)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .wr_stat     (wr_stat),
        .wr_ctrl     (wr_ctrl),
        .wr_txd      (wr_txd),
        .rd_stat     (rd_stat),
        .rd_pop      (rd_pop),
        .wbyte       (wbyte),
        .ctrl_q      (ctrl_q),
        .trig_code   (fctl_q[7:6]),
        .rx_count    (rx_count),
        .rx_push     (rx_push),
        .rx_idle_tmo (rx_idle_tmo),
        .brk_det     (brk_det),
        .flags       (flags),
        .rx_irq      (rx_irq)
    );

    sercfg_rdmux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd       (rd),
        .sel      (sel),
        .mode_q   (mode_q),
        .baud_q   (baud_q),
        .ctrl_q   (ctrl_q),
        .port_q   (port_q),
        .fctl_q   (fctl_q),
        .status   (pack_status(flags)),
        .rx_count (rx_count),
        .rx_head  (rx_head),
        .rdata    (bus_rdata)
    );

    assign mode_o = mode_q;
    assign baud_o = baud_q;
    assign ctrl_o = ctrl_q;
    assign port_o = port_q;
    assign tx_irq = ctrl_q[CTL_TXIE];

    a_r7_tx_strobe_byte: assert property (@(posedge clk) disable iff (rst)
        wr_txd |=> (tx_strobe && tx_byte == $past(bus_wdata[7:0])));
    a_r12_fifo_clear_pulse: assert property (@(posedge clk) disable iff (rst)
        (wr_fctl && bus_wdata[FC_RXRST]) |=> fifo_clr);
    a_r3_ctrl_masked: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> ((ctrl_o & ~CTRL_KEEP) == 8'h00));

endmodule

// File: tb/tb_sercfg_regs.sv
module tb_sercfg_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [4:0]  rx_count = '0;
    logic [7:0]  rx_head = '0;
    logic        rx_push = 1'b0, rx_idle_tmo = 1'b0, brk_det = 1'b0;
    logic        rx_pop, fifo_clr, tx_strobe, tx_irq, rx_irq;
    logic [7:0]  tx_byte, mode_o, baud_o, ctrl_o, port_o;
    int          nvec = 0, nbad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    sercfg_regs dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_count(rx_count),
        .rx_head(rx_head), .rx_push(rx_push), .rx_pop(rx_pop), .rx_idle_tmo(rx_idle_tmo),
        .brk_det(brk_det), .fifo_clr(fifo_clr), .tx_strobe(tx_strobe), .tx_byte(tx_byte),
        .mode_o(mode_o), .baud_o(baud_o), .ctrl_o(ctrl_o), .port_o(port_o),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    localparam logic [5:0] A_MODE = 6'h00, A_BAUD = 6'h04, A_CTRL = 6'h08, A_TXD = 6'h0C,
                           A_STAT = 6'h10, A_RXD = 6'h14, A_FCTL = 6'h18, A_CNT = 6'h1C,
                           A_PORT = 6'h20, A_LSR = 6'h24;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); d = bus_rdata; bus_rd = 1'b0;
    endtask

    task automatic push(input logic [4:0] occ);
        @(negedge clk); rx_count = occ; rx_push = 1'b1;
        @(negedge clk); rx_push = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R2 tx_irq", 16'(tx_irq), 16'h0);
        check("R2 rx_irq", 16'(rx_irq), 16'h0);
        check("R2 strobes", {14'h0, tx_strobe, fifo_clr}, 16'h0);
        check("R2 mode_o", 16'(mode_o), 16'h00);
        check("R2 baud_o", 16'(baud_o), 16'hFF);
        check("R2 ctrl_o", 16'(ctrl_o), 16'h20);
        rd(A_PORT, d); check("R2 port", d, 16'h0);
        rd(A_FCTL, d); check("R2 fifo control", d, 16'h0);
        rd(A_STAT, d); check("R2 R4 status after reset", d, 16'h60);
    endtask

    task automatic t_masks();
        logic [15:0] d;
        wr(A_MODE, 16'h00FF); rd(A_MODE, d); check("R3 mode mask", d, 16'h7B);
        wr(A_PORT, 16'h00FF); rd(A_PORT, d); check("R3 port mask", d, 16'hF3);
        wr(A_BAUD, 16'h005A); rd(A_BAUD, d); check("R3 bit rate", d, 16'h5A);
        wr(A_FCTL, 16'h1234); rd(A_FCTL, d); check("R3 fifo control word", d, 16'h1234);
        wr(A_FCTL, 16'h0000);
    endtask

    task automatic t_tx();
        logic [15:0] d;
        @(negedge clk); bus_wr = 1'b1; bus_addr = A_TXD; bus_wdata = 16'h33C5;
        @(negedge clk); bus_wr = 1'b0;
        check("R7 tx_strobe high", 16'(tx_strobe), 16'h1);
        check("R7 tx_byte", 16'(tx_byte), 16'hC5);
        @(negedge clk);
        check("R7 tx_strobe one cycle", 16'(tx_strobe), 16'h0);
        rd(A_STAT, d); check("R7 tde cleared", d, 16'h40);
        rd(A_STAT, d); check("R4 rearm after read", d, 16'h60);
    endtask

    task automatic t_ctrl();
        logic [15:0] d;
        wr(A_STAT, 16'h0000);
        rd(A_STAT, d); check("R5 R4 read returns old flags", d, 16'h00);
        rd(A_STAT, d); check("R4 flags rearmed", d, 16'h60);
        wr(A_CTRL, 16'h0000); wr(A_STAT, 16'h0000);
        rd(A_STAT, d); check("R4 no rearm when tx off", d, 16'h00);
        rd(A_STAT, d); check("R4 still no rearm", d, 16'h00);
        wr(A_CTRL, 16'h0000);
        rd(A_STAT, d); check("R6 tx off sets end", d, 16'h40);
        wr(A_STAT, 16'h00FF);
        rd(A_STAT, d); check("R5 ones leave flags", d, 16'h40);
        wr(A_CTRL, 16'h00FF);
        check("R3 ctrl mask", 16'(ctrl_o), 16'hFA);
        check("R6 tx_irq follows bit7", 16'(tx_irq), 16'h1);
        rd(A_CTRL, d); check("R3 ctrl readback", d, 16'hFA);
        wr(A_CTRL, 16'h0060);
        check("R6 tx_irq low", 16'(tx_irq), 16'h0);
    endtask

    task automatic t_events();
        logic [15:0] d;
        wr(A_STAT, 16'h0000);
        @(negedge clk); brk_det = 1'b1; @(negedge clk); brk_det = 1'b0;
        rd(A_STAT, d); check("R8 break flag", d & 16'h13, 16'h10);
        wr(A_STAT, 16'h00EF);
        rd(A_STAT, d); check("R5 break cleared", d & 16'h10, 16'h00);
        @(negedge clk); rx_idle_tmo = 1'b1; @(negedge clk); rx_idle_tmo = 1'b0;
        check("R8 timeout raises rx_irq", 16'(rx_irq), 16'h1);
        rd(A_STAT, d); check("R8 data ready", d & 16'h13, 16'h01);
        wr(A_STAT, 16'h00FE);
        check("R10 status bit0 clear drops rx_irq", 16'(rx_irq), 16'h0);
        rd(A_STAT, d); check("R5 data ready cleared", d & 16'h01, 16'h00);
    endtask

    task automatic t_trigger();
        logic [15:0] d;
        wr(A_FCTL, 16'h0000); wr(A_STAT, 16'h0000);
        push(5'd0);
        check("R9 trig1 rx_irq", 16'(rx_irq), 16'h1);
        rd(A_STAT, d); check("R9 trig1 full", d & 16'h02, 16'h02);
        wr(A_STAT, 16'h00FD);
        check("R10 status bit1 clear drops rx_irq", 16'(rx_irq), 16'h0);
        wr(A_FCTL, 16'h00C0);
        push(5'd12);
        check("R9 trig14 below", 16'(rx_irq), 16'h0);
        push(5'd13);
        check("R9 trig14 reached", 16'(rx_irq), 16'h1);
        wr(A_STAT, 16'h0000); wr(A_FCTL, 16'h0040);
        push(5'd2);
        rd(A_STAT, d); check("R9 trig4 below", d & 16'h02, 16'h00);
        push(5'd3);
        rd(A_STAT, d); check("R9 trig4 reached", d & 16'h02, 16'h02);
        wr(A_STAT, 16'h0000); wr(A_FCTL, 16'h0080);
        push(5'd6);
        check("R9 trig8 below", 16'(rx_irq), 16'h0);
        push(5'd7);
        check("R9 trig8 reached", 16'(rx_irq), 16'h1);
        wr(A_CTRL, 16'h0020);
        check("R10 ctrl bit6 clear drops rx_irq", 16'(rx_irq), 16'h0);
        wr(A_STAT, 16'h0000);
        push(5'd9);
        check("R9 no irq when disabled", 16'(rx_irq), 16'h0);
        rd(A_STAT, d); check("R9 full without irq", d & 16'h02, 16'h02);
    endtask

    task automatic t_rxread();
        logic [15:0] d;
        wr(A_CTRL, 16'h0060); wr(A_FCTL, 16'h0040); wr(A_STAT, 16'h0000);
        push(5'd3);
        rx_head = 8'hA5; rx_count = 5'd5;
        @(negedge clk); bus_rd = 1'b1; bus_addr = A_RXD;
        #1 check("R11 pop asserted", 16'(rx_pop), 16'h1);
        @(negedge clk); d = bus_rdata; bus_rd = 1'b0;
        check("R11 head returned", d, 16'hA5);
        rd(A_STAT, d); check("R11 full kept at 4 left", d & 16'h02, 16'h02);
        rx_head = 8'h3C; rx_count = 5'd4;
        rd(A_RXD, d); check("R11 second byte", d, 16'h3C);
        rd(A_STAT, d); check("R11 full cleared at 3 left", d & 16'h02, 16'h00);
        rx_count = 5'd0;
        @(negedge clk); bus_rd = 1'b1; bus_addr = A_RXD;
        #1 check("R11 no pop when empty", 16'(rx_pop), 16'h0);
        @(negedge clk); d = bus_rdata; bus_rd = 1'b0;
        check("R11 empty reads zero", d, 16'h0);
        rx_count = 5'd9;
        rd(A_CNT, d); check("R13 count readback", d, 16'h9);
        rx_count = 5'd16;
        rd(A_CNT, d); check("R13 count full", d, 16'h10);
        rx_count = 5'd0;
    endtask

    task automatic t_fifo_reset();
        logic [15:0] d;
        @(negedge clk); bus_wr = 1'b1; bus_addr = A_FCTL; bus_wdata = 16'h0042;
        @(negedge clk); bus_wr = 1'b0;
        check("R12 fifo_clr pulse", 16'(fifo_clr), 16'h1);
        @(negedge clk);
        check("R12 fifo_clr one cycle", 16'(fifo_clr), 16'h0);
        rd(A_FCTL, d); check("R12 fifo control stored", d, 16'h42);
    endtask

    task automatic t_unmapped();
        logic [15:0] d;
        rd(A_LSR, d); check("R1 line status reads 0", d, 16'h0);
        rd(6'h28, d); check("R1 unmapped 0x28", d, 16'h0);
        rd(6'h3C, d); check("R1 unmapped 0x3C", d, 16'h0);
        rd(6'h09, d); check("R1 misaligned", d, 16'h0);
        rd(A_TXD, d); check("R1 transmit data reads 0", d, 16'h0);
        wr(A_LSR, 16'hFFFF); wr(6'h28, 16'hFFFF); wr(6'h01, 16'hFFFF);
        wr(A_CNT, 16'hFFFF); wr(A_RXD, 16'hFFFF);
        check("R1 mode untouched", 16'(mode_o), 16'h7B);
        check("R1 bit rate untouched", 16'(baud_o), 16'h5A);
        check("R1 ctrl untouched", 16'(ctrl_o), 16'h60);
        check("R1 port untouched", 16'(port_o), 16'hF3);
        rd(A_FCTL, d); check("R1 fifo control untouched", d, 16'h42);
        @(negedge clk); bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = A_BAUD; bus_wdata = 16'h0011;
        @(negedge clk); d = bus_rdata; bus_wr = 1'b0; bus_rd = 1'b0;
        check("R1 read dropped on write", d, 16'h0);
        check("R1 write taken", 16'(baud_o), 16'h11);
    endtask

    task automatic t_race();
        logic [15:0] d;
        wr(A_FCTL, 16'h0000); wr(A_CTRL, 16'h0060); wr(A_STAT, 16'h0000);
        @(negedge clk); bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 16'h0000;
        rx_count = 5'd0; rx_push = 1'b1; brk_det = 1'b1;
        @(negedge clk); bus_wr = 1'b0; rx_push = 1'b0; brk_det = 1'b0;
        check("R14 irq survives status clear", 16'(rx_irq), 16'h1);
        rd(A_STAT, d); check("R14 flags survive status clear", d & 16'h12, 16'h12);
        wr(A_STAT, 16'h0000);
        @(negedge clk); bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 16'h0020;
        rx_push = 1'b1;
        @(negedge clk); bus_wr = 1'b0; rx_push = 1'b0;
        check("R14 ctrl clear wins", 16'(rx_irq), 16'h0);
        rd(A_STAT, d); check("R14 full still set", d & 16'h02, 16'h02);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_masks();
        t_tx();
        t_ctrl();
        t_events();
        t_trigger();
        t_rxread();
        t_fifo_reset();
        t_unmapped();
        t_race();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nvec++;
            nbad++;
            $display("FAIL watchdog R1..R14 run incomplete actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule